// File: doc/BRIEF.md
# Multiplexed Host Port Write Interface

This block is a slave port through which an external host writes into local memory over a 16-bit multiplexed data bus. The host reaches a 32-bit register as two halfword cycles. A halfword-select input marks each cycle: the low half comes first and the high half second. A 2-bit control field picks the target of the cycle: a control register, the address register, the data register with address autoincrement, or the data register without autoincrement.

Autoincrement data words are posted into an 8-entry write FIFO. Each entry carries the address it is written to, and the FIFO drains over a valid/ready memory write port. A busy output holds the host back in three cases: while an unbuffered word reaches memory, while an address update waits for the FIFO to drain, and while a posted word waits for a free entry. The access strobe is chip select and host strobe, both active low. It is synchronised to the block clock, and each access is taken on the synchronised start of the strobe.

Top module: `hwp_write_port`

## Requirements
- R1: Control code 00 selects the control register, 10 the address register, 01 data with autoincrement and 11 data without autoincrement. A control-register write produces no memory write and leaves the address register unchanged.
- R2: Halfword select 0 carries bits 15:0 and select 1 carries bits 31:16 of the register. The data word is formed when the second halfword arrives. The first halfword of a data access never asserts busy.
- R3: A control-register write never asserts busy.
- R4: For a data write without autoincrement, busy forms exactly one period during the second halfword. That period lasts until the word has been written to memory. The address register does not change.
- R5: The memory port keeps valid, address and data stable until ready is seen. Each accepted handshake is one write, and writes leave in the order the host issued them. After reset, busy and valid are low.
- R6: An autoincrement data write into a FIFO that has space never asserts busy. Each posted word advances the address register by 4.
- R7: An address-register write made while the FIFO is empty raises one busy period of ADDR_STALL clocks on each halfword.
- R8: If the FIFO holds data when the first halfword of an address write starts, busy stays high until the FIFO is empty. Busy then goes low for one clock, and a second period of ADDR_STALL clocks follows. The queued words go out at their own addresses.
- R9: An autoincrement word that arrives when all FIFO_DEPTH entries are pending raises busy until an entry frees. The word is then posted and is not lost.
- R10: The strobe is active only while chip select and host strobe are both low. A busy response appears on the third clock edge after the strobe becomes active. Strobe activity while chip select is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| strb_ni | input | 1 | Host strobe, active low |
| ctl_i | input | 2 | Access target code |
| hsel_i | input | 1 | Halfword select: 0 for the first (low) half, 1 for the second (high) half |
| data_i | input | 16 | Host write halfword |
| busy_o | output | 1 | Host stall, high while the block is not ready |
| mem_valid_o | output | 1 | Memory write request |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_data_o | output | 32 | Memory write word |

## Verification
Two synchroniser flops and a registered sequencer lie between the host strobe and busy. A busy response is therefore first visible after the third rising edge that follows the strobe. The host task samples at falling edges and checks that delay for an unbuffered write. For every halfword, the host model holds the strobe until busy has stayed low for four clocks. It counts the busy periods in that window and compares the count with the value expected for the target and FIFO state. The FIFO never drains during the one-clock gap of an address write, so that gap cannot end the window early. A memory model checks each clock, two nanoseconds before the rising edge that completes a handshake, against a queue of expected address and data pairs.

// File: rtl/hwp_pkg.sv
package hwp_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int ADDR_INC = WORD_W / 8;

  typedef enum logic [1:0] {
    CTL_CFG  = 2'b00,
    CTL_AINC = 2'b01,
    CTL_ADDR = 2'b10,
    CTL_DATA = 2'b11
  } ctl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_GAP,
    ST_ASTALL,
    ST_PUSHW,
    ST_FLUSH
  } st_e;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_ent_t;
endpackage

// File: rtl/hwp_strobe_sync.sv
module hwp_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic strb_ni,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              raw;

  assign raw = ~cs_ni & ~strb_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      prev_q <= sh_q[STAGES-1];
    end
  end

  // start of an access = active-low strobe falling, seen after sync
  assign fall_o = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hwp_wfifo.sv
module hwp_wfifo import hwp_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  wr_ent_t push_ent_i,
  output logic    full_o,
  output logic    empty_o,
  output logic    out_valid_o,
  output wr_ent_t out_ent_o,
  input  logic    out_ready_i
);
  localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  wr_ent_t       mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o      = (cnt_q == CW'(DEPTH));
  assign empty_o     = (cnt_q == '0);
  assign out_valid_o = ~empty_o;
  assign out_ent_o   = mem_q[rp_q];
  assign do_push     = push_i & ~full_o;
  assign do_pop      = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= push_ent_i;
        wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/hwp_seq.sv
module hwp_seq import hwp_pkg::*; #(
  parameter int ADDR_STALL = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [1:0]        ctl_i,
  input  logic              hsel_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic              full_i,
  input  logic              empty_i,
  output logic              push_o,
  output wr_ent_t           push_ent_o,
  output logic              busy_o
);
  localparam int SCW = (ADDR_STALL < 2) ? 1 : $clog2(ADDR_STALL);

  st_e               st_q, st_d;
  logic [WORD_W-1:0] addr_q, word_q;
  logic [HALF_W-1:0] lo_q;
  logic              inc_q, push_inc, take;
  logic [SCW-1:0]    cnt_q;

  assign take = (st_q == ST_IDLE) && fall_i;

  always_comb begin
    st_d            = st_q;
    push_o          = 1'b0;
    push_inc        = 1'b0;
    push_ent_o.addr = addr_q;
    push_ent_o.data = {data_i, lo_q};
    case (st_q)
      ST_IDLE: if (fall_i) begin
        if (ctl_i == CTL_ADDR) begin
          st_d = (!hsel_i && !empty_i) ? ST_DRAIN : ST_ASTALL;
        end else if (ctl_i[0] && hsel_i) begin
          if (!full_i) begin
            push_o   = 1'b1;
            push_inc = (ctl_i == CTL_AINC);
            st_d     = push_inc ? ST_IDLE : ST_FLUSH;
          end else begin
            st_d = ST_PUSHW;
          end
        end
      end
      ST_PUSHW: begin
        push_ent_o.data = word_q;
        if (!full_i) begin
          push_o   = 1'b1;
          push_inc = inc_q;
          st_d     = inc_q ? ST_IDLE : ST_FLUSH;
        end
      end
      ST_DRAIN:  if (empty_i) st_d = ST_GAP;
      ST_GAP:    st_d = ST_ASTALL;
      ST_ASTALL: if (cnt_q == '0) st_d = ST_IDLE;
      ST_FLUSH:  if (empty_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      word_q <= '0;
      lo_q   <= '0;
      inc_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == ST_ASTALL && st_q != ST_ASTALL) cnt_q <= SCW'(ADDR_STALL - 1);
      else if (st_q == ST_ASTALL && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      if (take && ctl_i == CTL_ADDR) begin
        if (hsel_i) addr_q[WORD_W-1:HALF_W] <= data_i;
        else        addr_q[HALF_W-1:0]      <= data_i;
      end else if (push_o && push_inc) begin
        addr_q <= addr_q + WORD_W'(ADDR_INC);
      end
      if (take && ctl_i[0]) begin
        if (!hsel_i) begin
          lo_q <= data_i;
        end else begin
          word_q <= {data_i, lo_q};
          inc_q  <= (ctl_i == CTL_AINC);
        end
      end
    end
  end

  assign busy_o = (st_q == ST_DRAIN) || (st_q == ST_ASTALL) ||
                  (st_q == ST_PUSHW) || (st_q == ST_FLUSH);
endmodule

// File: rtl/hwp_write_port.sv
module hwp_write_port import hwp_pkg::*; #(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_STALL  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              strb_ni,
  input  logic [1:0]        ctl_i,
  input  logic              hsel_i,
  input  logic [HALF_W-1:0] data_i,
  output logic              busy_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o
);
  logic    fall_w, push_w, full_w, empty_w;
  wr_ent_t push_ent_w, head_w;

  hwp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cs_ni  (cs_ni),
    .strb_ni(strb_ni),
    .fall_o (fall_w)
  );

  hwp_seq #(.ADDR_STALL(ADDR_STALL)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fall_i    (fall_w),
    .ctl_i     (ctl_i),
    .hsel_i    (hsel_i),
    .data_i    (data_i),
    .full_i    (full_w),
    .empty_i   (empty_w),
    .push_o    (push_w),
    .push_ent_o(push_ent_w),
    .busy_o    (busy_o)
  );

  hwp_wfifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push_w),
    .push_ent_i (push_ent_w),
    .full_o     (full_w),
    .empty_o    (empty_w),
    .out_valid_o(mem_valid_o),
    .out_ent_o  (head_w),
    .out_ready_i(mem_ready_i)
  );

  assign mem_addr_o = head_w.addr;
  assign mem_data_o = head_w.data;
endmodule

// File: rtl/hwp_write_port_chk.sv
module hwp_write_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fall_i,
  input logic [1:0]  ctl_i,
  input logic        hsel_i,
  input logic        busy_i,
  input logic        mem_valid_i,
  input logic        mem_ready_i,
  input logic [31:0] mem_addr_i,
  input logic [31:0] mem_data_i
);
  a_r3_cfg_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !busy_i && ctl_i == 2'b00) |=> !busy_i);

  a_r2_first_half_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !busy_i && !hsel_i && ctl_i[0]) |=> !busy_i);

  a_r4_data_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !busy_i && hsel_i && ctl_i == 2'b11) |=> busy_i);

  a_r7_addr_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !busy_i && ctl_i == 2'b10) |=> busy_i);

  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_i && !mem_ready_i) |=>
      (mem_valid_i && $stable(mem_addr_i) && $stable(mem_data_i)));
endmodule

bind hwp_write_port hwp_write_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fall_i     (fall_w),
  .ctl_i      (ctl_i),
  .hsel_i     (hsel_i),
  .busy_i     (busy_o),
  .mem_valid_i(mem_valid_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_i (mem_addr_o),
  .mem_data_i (mem_data_o)
);

// File: tb/hwp_write_port_test.sv
`timescale 1ns/1ps
module hwp_write_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, strb_n = 1'b1, hsel = 1'b0, ready = 1'b1;
  logic [1:0]  ctl = 2'b00;
  logic [15:0] data = '0;
  logic        busy, mvalid;
  logic [31:0] maddr, mdata;

  int total = 0, bad = 0;
  logic [63:0] expq[$];
  logic [31:0] model_addr = '0;
  int first;

  always #4 clk = ~clk;

  hwp_write_port uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .strb_ni(strb_n),
    .ctl_i(ctl), .hsel_i(hsel), .data_i(data), .busy_o(busy),
    .mem_valid_o(mvalid), .mem_ready_i(ready),
    .mem_addr_o(maddr), .mem_data_o(mdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory model: checked 2 ns before the edge that completes a handshake
  always begin
    @(negedge clk);
    #2;
    if (rst_n && mvalid && ready) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected write", {maddr, mdata}, 64'h0);
      else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk({maddr, mdata} == e, "R5 write addr/data/order", {maddr, mdata}, e);
      end
    end
  end

  task automatic host_half(input logic [1:0] c, input logic h, input logic [15:0] d,
                           input int exp_per, input string tag, output int fb);
    int per, low_run, n;
    logic prev;
    per = 0; low_run = 0; n = 0; prev = 1'b0; fb = -1;
    @(negedge clk);
    ctl = c; hsel = h; data = d; cs_n = 1'b0; strb_n = 1'b0;
    while (!(n >= 6 && low_run >= 4)) begin
      @(negedge clk);
      n++;
      if (busy && !prev) per++;
      if (busy && fb < 0) fb = n;
      prev = busy;
      low_run = busy ? 0 : low_run + 1;
    end
    strb_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(per == exp_per, tag, 64'(per), 64'(exp_per));
  endtask

  task automatic wr32(input logic [1:0] c, input logic [31:0] w, input int p0, input int p1,
                      input string tag);
    int fb;
    if (c == 2'b01) begin expq.push_back({model_addr, w}); model_addr += 4; end
    if (c == 2'b11) expq.push_back({model_addr, w});
    if (c == 2'b10) model_addr = w;
    host_half(c, 1'b0, w[15:0], p0, {tag, " first half busy periods"}, fb);
    host_half(c, 1'b1, w[31:16], p1, {tag, " second half busy periods"}, fb);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 64'h0, 64'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R5 reset busy low", 64'(busy), 64'h0);
    chk(mvalid == 1'b0, "R5 reset valid low", 64'(mvalid), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: address write, FIFO empty
    wr32(2'b10, 32'h0000_0100, 1, 1, "R7 addr empty fifo");
    // R3 / R1: control write is quiet and does not move the address
    wr32(2'b00, 32'hDEAD_BEEF, 0, 0, "R3 control write");
    chk(expq.size() == 0, "R1 control write adds no memory write", 64'(expq.size()), 64'h0);

    // R4 / R10: unbuffered data write, busy latency on second half
    expq.push_back({model_addr, 32'h1122_3344});
    host_half(2'b11, 1'b0, 16'h3344, 0, "R2 first half quiet", first);
    host_half(2'b11, 1'b1, 16'h1122, 1, "R4 noinc second half", first);
    chk(first == 3, "R10 busy on third edge", 64'(first), 64'd3);
    wr32(2'b11, 32'h5566_7788, 0, 1, "R4 noinc same address");

    // R6: autoincrement words
    wr32(2'b01, 32'hA000_0001, 0, 0, "R6 ainc 0");
    wr32(2'b01, 32'hA000_0002, 0, 0, "R6 ainc 1");
    wr32(2'b01, 32'hA000_0003, 0, 0, "R6 ainc 2");
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R6 ainc words drained", 64'(expq.size()), 64'h0);

    // R8: address write with FIFO holding data
    ready = 1'b0;
    wr32(2'b10, 32'h0000_0200, 1, 1, "R8 setup addr");
    wr32(2'b01, 32'hB000_0001, 0, 0, "R8 queued 0");
    wr32(2'b01, 32'hB000_0002, 0, 0, "R8 queued 1");
    wr32(2'b01, 32'hB000_0003, 0, 0, "R8 queued 2");
    chk(expq.size() == 3, "R8 words held while ready low", 64'(expq.size()), 64'd3);
    model_addr = 32'h0000_0300;
    fork
      host_half(2'b10, 1'b0, 16'h0300, 2, "R8 drain plus stall periods", first);
      begin repeat (20) @(negedge clk); ready = 1'b1; end
    join
    chk(expq.size() == 0, "R8 fifo drained before address stall", 64'(expq.size()), 64'h0);
    host_half(2'b10, 1'b1, 16'h0000, 1, "R8 address second half", first);
    wr32(2'b01, 32'hCAFE_0001, 0, 0, "R8 ainc at new address");

    // R9: FIFO full
    repeat (6) @(negedge clk);
    ready = 1'b0;
    wr32(2'b10, 32'h0000_0400, 1, 1, "R9 setup addr");
    for (int k = 0; k < 8; k++) wr32(2'b01, 32'hD000_0000 + k, 0, 0, "R9 fill");
    chk(mvalid == 1'b1, "R9 valid held while ready low", 64'(mvalid), 64'h1);
    expq.push_back({model_addr, 32'hD000_0099}); model_addr += 4;
    host_half(2'b01, 1'b0, 16'h0099, 0, "R9 ninth first half", first);
    fork
      host_half(2'b01, 1'b1, 16'hD000, 1, "R9 full stall", first);
      begin repeat (30) @(negedge clk); ready = 1'b1; end
    join
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R9 ninth word not lost", 64'(expq.size()), 64'h0);

    // R10: strobe with chip select high is ignored
    begin
      int hits;
      hits = 0;
      @(negedge clk);
      ctl = 2'b01; hsel = 1'b1; data = 16'hFFFF; cs_n = 1'b1; strb_n = 1'b0;
      repeat (10) begin @(negedge clk); if (busy || mvalid) hits++; end
      strb_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(hits == 0, "R10 cs high ignored", 64'(hits), 64'h0);
    end
    wr32(2'b01, 32'h0BAD_F00D, 0, 0, "R10 address unaffected");
    repeat (10) @(negedge clk);
    chk(expq.size() == 0, "R5 all writes delivered", 64'(expq.size()), 64'h0);
    chk(model_addr == 32'h0000_0428, "R6 model address sequence", 64'(model_addr), 64'h428);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule